// File: doc/BRIEF.md
# NAND Controller Event Status and Interrupt Registers

This block holds the control word and the event status word of a NAND flash controller, together with the single interrupt line that summarises them. The datapath and the command sequencer report events as one-cycle pulses on a 12-bit event input. Each pulse sets a sticky flag in the status word. The host clears flags by writing ones to the status word, and it configures the controller through the control word. The control word carries a run bit, DMA, ECC and spare-area enables, a read-ID byte count, two self-clearing strobes and a 12-bit interrupt mask.

A mask bit set to one disables the matching interrupt, and a mask bit set to zero enables it. After reset every interrupt is disabled. The interrupt output is registered. It goes high when any flag is set while its mask bit is zero, and it stays high until that flag is cleared or masked.

The host uses a simple synchronous write port and a combinational read port, both selected by a byte address. The control word sits at offset 0x0 and the status word at offset 0x4. Every other address reads zero and ignores writes.

Top module: `nfc_irq_regs`

## Requirements
- R1: After reset the control word reads 0x0000_0FFF (all twelve interrupts masked, every enable off), the status word reads 0 and `irq_o` is low.
- R2: A one on `evt_i[k]` at a clock edge sets status bit k at that edge. The flag then stays set until the host clears it. The event indices are: 11 ready, 10 and 9 page done for chip select 0 and 1, 8 and 7 command done for chip select 0 and 1, 6 and 5 bad block for chip select 0 and 1, 4 double-bit ECC error, 3 single-bit ECC error, 2 write-data request, 1 read-data request, 0 write-command request.
- R3: A write to the status word (offset 0x4) clears every flag whose write-data bit in 11:0 is one. Flags whose write-data bit is zero keep their value. Writing 0xFFF clears all flags.
- R4: When an event and a host clear hit the same flag in the same cycle, the flag ends up set.
- R5: `irq_o` equals, one cycle later, the OR over k of (status bit k AND NOT mask bit k).
- R6: Mask bits are control bits 11:0, aligned to the status bits. A one disables that interrupt but still lets the flag be recorded. A zero enables it.
- R7: Status bits 31:12 always read zero, and write data in those bits has no effect.
- R8: Control bit 28 drives `run_o`, bit 29 `dma_en_o`, bit 30 `ecc_en_o`, bit 31 `spare_en_o`, and bits 18:16 drive `id_bytes_o`. All of them read back as written.
- R9: Writing a one to control bit 19 raises `ecc_clr_o` for exactly the following cycle. Writing a one to control bit 20 does the same for `pgcnt_clr_o`. Both bits read back as zero.
- R10: Control bits 27:21 and 15:12 read zero whatever is written to them.
- R11: Addresses other than 0x0 and 0x4 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host write strobe, one cycle per write |
| reg_addr | input | ADDR_W (4) | Host byte address for both read and write |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_i | input | 12 | Event pulses from the datapath and sequencer, bit k sets flag k |
| irq_o | output | 1 | Registered interrupt request |
| run_o | output | 1 | Controller run enable |
| dma_en_o | output | 1 | DMA transfer enable |
| ecc_en_o | output | 1 | ECC enable |
| spare_en_o | output | 1 | Spare-area transfer enable |
| id_bytes_o | output | 3 | Number of ID bytes to read back |
| ecc_clr_o | output | 1 | One-cycle strobe that clears the ECC logic |
| pgcnt_clr_o | output | 1 | One-cycle strobe that clears the page count |

## Verification
The assertions take the event inputs to be synchronous, single-cycle pulses. They take a host write to be a one-cycle `reg_wr` with a stable address and data, and they take reset to be held for at least one clock before the first event. The bench drives every input on the falling edge and releases `reg_wr` after one cycle. It starts events only after reset has been released, so each flag change can be traced to one edge. The directed sequences place events in the same cycle as clears, with masked and unmasked flags. A pseudo-random phase then mixes writes and events under those same rules.

// File: rtl/nfc_regs_pkg.sv
// Package: nfc_regs_pkg
// Shared constants and types for the NAND controller event/interrupt registers.
// Assumes a 32-bit host data word and twelve event flags.
package nfc_regs_pkg;

    localparam int DATA_W     = 32;
    localparam int NFLAGS     = 12;
    localparam int IDCNT_W    = 3;

    // control word bit positions
    localparam int RUN_BIT    = 28;
    localparam int DMA_BIT    = 29;
    localparam int ECC_BIT    = 30;
    localparam int SPARE_BIT  = 31;
    localparam int IDCNT_LSB  = 16;
    localparam int ECCCLR_BIT = 19;
    localparam int PGCLR_BIT  = 20;

    // event flag indices (the status bit a pulse sets)
    typedef enum int {
        FLG_WCMD_REQ  = 0,
        FLG_RDATA_REQ = 1,
        FLG_WDATA_REQ = 2,
        FLG_ECC_SGL   = 3,
        FLG_ECC_DBL   = 4,
        FLG_BADBLK_C1 = 5,
        FLG_BADBLK_C0 = 6,
        FLG_CMDDONE_C1 = 7,
        FLG_CMDDONE_C0 = 8,
        FLG_PGDONE_C1 = 9,
        FLG_PGDONE_C0 = 10,
        FLG_READY     = 11
    } flag_idx_e;

    // retained control fields
    typedef struct packed {
        logic               spare_en;
        logic               ecc_en;
        logic               dma_en;
        logic               run;
        logic [IDCNT_W-1:0] id_cnt;
        logic [NFLAGS-1:0]  mask;
    } ctrl_t;

    localparam logic [NFLAGS-1:0] MASK_RESET = {NFLAGS{1'b1}};

endpackage

// File: rtl/nfc_ctrl_reg.sv
// Module: nfc_ctrl_reg
// Holds the control word: enables, ID byte count and interrupt mask, and
// turns writes of the two clear bits into one-cycle strobes.
// Assumes wr_en is a single-cycle strobe already qualified by the address.
module nfc_ctrl_reg
    import nfc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              ecc_clr_q,
    output logic              pg_clr_q,
    output logic [DATA_W-1:0] rdback
);

    ctrl_t ctrl_d;
    logic  unused_bits;

    // decode write data into the retained fields
    always_comb begin
        ctrl_d.spare_en = wdata[SPARE_BIT];
        ctrl_d.ecc_en   = wdata[ECC_BIT];
        ctrl_d.dma_en   = wdata[DMA_BIT];
        ctrl_d.run      = wdata[RUN_BIT];
        ctrl_d.id_cnt   = wdata[IDCNT_LSB +: IDCNT_W];
        ctrl_d.mask     = wdata[NFLAGS-1:0];
    end

    assign unused_bits = ^{wdata[27:21], wdata[15:12]};

    // retained control state, all interrupts masked at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{spare_en: 1'b0, ecc_en: 1'b0, dma_en: 1'b0, run: 1'b0,
                        id_cnt: '0, mask: MASK_RESET};
        end else if (wr_en) begin
            ctrl_q <= ctrl_d;
        end
    end

    // self-clearing strobes, one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_clr_q <= 1'b0;
            pg_clr_q  <= 1'b0;
        end else begin
            ecc_clr_q <= wr_en & wdata[ECCCLR_BIT];
            pg_clr_q  <= wr_en & wdata[PGCLR_BIT];
        end
    end

    // read-back image; strobe bits and reserved bits read zero
    always_comb begin
        rdback = '0;
        rdback[SPARE_BIT]              = ctrl_q.spare_en;
        rdback[ECC_BIT]                = ctrl_q.ecc_en;
        rdback[DMA_BIT]                = ctrl_q.dma_en;
        rdback[RUN_BIT]                = ctrl_q.run;
        rdback[IDCNT_LSB +: IDCNT_W]   = ctrl_q.id_cnt;
        rdback[NFLAGS-1:0]             = ctrl_q.mask;
    end

endmodule

// File: rtl/nfc_stat_flags.sv
// Module: nfc_stat_flags
// Sticky event flags: a pulse sets a flag, a host write of ones clears it,
// and a set in the same cycle as a clear wins.
// Assumes set_i bits are synchronous single-cycle pulses.
module nfc_stat_flags
    import nfc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_i,
    input  logic              clr_en,
    input  logic [NFLAGS-1:0] clr_bits,
    output logic [NFLAGS-1:0] flags_q
);

    for (genvar k = 0; k < NFLAGS; k++) begin : g_flag
        logic clr_k;
        assign clr_k = clr_en & clr_bits[k];

        // one sticky flag; set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[k] <= 1'b0;
            end else if (set_i[k]) begin
                flags_q[k] <= 1'b1;
            end else if (clr_k) begin
                flags_q[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nfc_irq_gen.sv
// Module: nfc_irq_gen
// Registered interrupt request: high when any flag is set with its mask bit
// at zero (mask one = disabled).
// Assumes flags and mask are register outputs in the same clock domain.
module nfc_irq_gen
    import nfc_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] flags,
    input  logic [NFLAGS-1:0] mask,
    output logic              irq_q
);

    logic [NFLAGS-1:0] pending;

    // flags that are allowed through the mask
    assign pending = flags & ~mask;

    // register the summary to keep the output glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |pending;
        end
    end

endmodule

// File: rtl/nfc_irq_regs.sv
// Module: nfc_irq_regs
// Top of the NAND controller control/status register pair and its interrupt.
// Decodes the host address, routes writes to the control word or the status
// word, and muxes read data. Assumes reg_wr is a one-cycle strobe.
module nfc_irq_regs
    import nfc_regs_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CTRL_OFS = 0,
    parameter int STAT_OFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [11:0]       evt_i,
    output logic              irq_o,
    output logic              run_o,
    output logic              dma_en_o,
    output logic              ecc_en_o,
    output logic              spare_en_o,
    output logic [2:0]        id_bytes_o,
    output logic              ecc_clr_o,
    output logic              pgcnt_clr_o
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic              sel_ctrl, sel_stat;
    logic              wr_ctrl, wr_stat;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] ctrl_rd;
    logic [NFLAGS-1:0] flags_q;

    // address decode
    assign sel_ctrl = (reg_addr == CTRL_A);
    assign sel_stat = (reg_addr == STAT_A);
    assign wr_ctrl  = reg_wr & sel_ctrl;
    assign wr_stat  = reg_wr & sel_stat;

    nfc_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ctrl),
        .wdata     (reg_wdata),
        .ctrl_q    (ctrl_q),
        .ecc_clr_q (ecc_clr_o),
        .pg_clr_q  (pgcnt_clr_o),
        .rdback    (ctrl_rd)
    );

    nfc_stat_flags u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt_i),
        .clr_en   (wr_stat),
        .clr_bits (reg_wdata[NFLAGS-1:0]),
        .flags_q  (flags_q)
    );

    nfc_irq_gen u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flags_q),
        .mask  (ctrl_q.mask),
        .irq_q (irq_o)
    );

    // read mux; unmapped addresses and upper status bits read zero
    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl)      reg_rdata = ctrl_rd;
        else if (sel_stat) reg_rdata[NFLAGS-1:0] = flags_q;
    end

    // control outputs
    assign run_o      = ctrl_q.run;
    assign dma_en_o   = ctrl_q.dma_en;
    assign ecc_en_o   = ctrl_q.ecc_en;
    assign spare_en_o = ctrl_q.spare_en;
    assign id_bytes_o = ctrl_q.id_cnt;

endmodule

// File: rtl/nfc_irq_regs_chk.sv
// Module: nfc_irq_regs_chk
// Assertion checker for nfc_irq_regs, attached with bind.
// Assumes synchronous active-low reset held for at least one clock.
module nfc_irq_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_ctrl,
    input logic        wr_stat,
    input logic [31:0] wdata,
    input logic [11:0] evt,
    input logic [11:0] flags,
    input logic [11:0] mask,
    input logic        irq,
    input logic        ecc_clr
);

    // R2: a pulse sets its flag at the next edge
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != 12'd0) |=> ((flags & $past(evt)) == $past(evt)));

    // R2: without a status write no flag falls
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((flags & $past(flags)) == $past(flags)));

    // R3: write-one-to-clear when no event competes
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && evt == 12'd0) |=> (flags == ($past(flags) & ~$past(wdata[11:0]))));

    // R4: set wins over a clear in the same cycle
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && evt != 12'd0) |=> ((flags & $past(evt)) == $past(evt)));

    // R5: interrupt follows unmasked flags one cycle later
    assert_irq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|($past(flags) & ~$past(mask)))));

    // R9: the ECC clear strobe lasts exactly the cycle after the write
    assert_ecc_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[19]) |=> ecc_clr);

    assert_ecc_strobe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl && wdata[19]) |=> !ecc_clr);

endmodule

bind nfc_irq_regs nfc_irq_regs_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wr_stat (wr_stat),
    .wdata   (reg_wdata),
    .evt     (evt_i),
    .flags   (flags_q),
    .mask    (ctrl_q.mask),
    .irq     (irq_o),
    .ecc_clr (ecc_clr_o)
);

// File: tb/test_nfc_irq_regs.sv
`timescale 1ns/100ps
// Bench: behavioural cycle model compared with nfc_irq_regs on every clock.
module test_nfc_irq_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [11:0] evt_i = 12'h0;
    logic        irq_o, run_o, dma_en_o, ecc_en_o, spare_en_o;
    logic [2:0]  id_bytes_o;
    logic        ecc_clr_o, pgcnt_clr_o;

    int checks = 0;
    int failures = 0;

    // reference model state
    bit [11:0] m_mask = 12'hFFF;
    bit [11:0] m_stat = 12'h0;
    bit        m_run = 0, m_dma = 0, m_ecc = 0, m_spare = 0;
    bit [2:0]  m_id = 3'd0;
    bit        m_irq = 0, m_eccclr = 0, m_pgclr = 0;

    always #2.5 clk = ~clk;

    nfc_irq_regs i_nfc_irq_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
        .irq_o(irq_o), .run_o(run_o), .dma_en_o(dma_en_o), .ecc_en_o(ecc_en_o),
        .spare_en_o(spare_en_o), .id_bytes_o(id_bytes_o),
        .ecc_clr_o(ecc_clr_o), .pgcnt_clr_o(pgcnt_clr_o)
    );

    function automatic bit [31:0] model_read(input bit [3:0] a);
        bit [31:0] r = 32'h0;
        if (a == 4'h0) r = {m_spare, m_ecc, m_dma, m_run, 7'h0, 2'b00, m_id, 4'h0, m_mask};
        else if (a == 4'h4) r = {20'h0, m_stat};
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive, compare before the edge, then advance the model
    task automatic step(input bit wr, input bit [3:0] a, input bit [31:0] wd,
                        input bit [11:0] ev, input string tag);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; evt_i = ev;
        #1;
        chk(tag, "rdata", reg_rdata, model_read(a));
        chk("R5", "irq", {31'h0, irq_o}, {31'h0, m_irq});
        chk("R8", "ctrl outputs", {25'h0, spare_en_o, ecc_en_o, dma_en_o, run_o, id_bytes_o},
            {25'h0, m_spare, m_ecc, m_dma, m_run, m_id});
        chk("R9", "strobes", {30'h0, ecc_clr_o, pgcnt_clr_o}, {30'h0, m_eccclr, m_pgclr});
        @(posedge clk);
        m_irq   = |(m_stat & ~m_mask);
        m_eccclr = wr && a == 4'h0 && wd[19];
        m_pgclr  = wr && a == 4'h0 && wd[20];
        if (wr && a == 4'h4) m_stat = m_stat & ~wd[11:0];
        m_stat = m_stat | ev;
        if (wr && a == 4'h0) begin
            {m_spare, m_ecc, m_dma, m_run} = wd[31:28];
            m_id = wd[18:16];
            m_mask = wd[11:0];
        end
    endtask

    task automatic idle(input bit [3:0] a, input string tag);
        step(0, a, 32'h0, 12'h0, tag);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        bit [15:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        idle(4'h0, "R1");
        idle(4'h4, "R1");
        // R2/R6: command-done CS0 recorded while masked, no interrupt
        step(0, 4'h4, 32'h0, 12'h100, "R2");
        idle(4'h4, "R6");
        idle(4'h4, "R6");
        // R6: unmask bit 8, interrupt rises
        step(1, 4'h0, 32'h0000_0EFF, 12'h0, "R6");
        idle(4'h0, "R6");
        idle(4'h4, "R5");
        // R3: clear it, interrupt falls
        step(1, 4'h4, 32'h0000_0100, 12'h0, "R3");
        idle(4'h4, "R3");
        idle(4'h4, "R5");
        // R3: zero bits leave flags alone
        step(0, 4'h4, 32'h0, 12'h003, "R2");
        step(1, 4'h4, 32'h0000_0001, 12'h0, "R3");
        idle(4'h4, "R3");
        // R4: set and clear on the same bit in the same cycle
        step(1, 4'h4, 32'h0000_0002, 12'h002, "R4");
        idle(4'h4, "R4");
        // R7: upper status write ignored, all flags read 0xFFF
        step(1, 4'h4, 32'hFFFF_F000, 12'h0, "R7");
        idle(4'h4, "R7");
        step(0, 4'h4, 32'h0, 12'hFFF, "R2");
        idle(4'h4, "R7");
        // R10/R9: all-ones control write
        step(1, 4'h0, 32'hFFFF_FFFF, 12'h0, "R10");
        idle(4'h0, "R10");
        idle(4'h0, "R9");
        // R8: run with five ID bytes, all interrupts enabled
        step(1, 4'h0, 32'h1005_0000, 12'h0, "R8");
        idle(4'h0, "R8");
        idle(4'h4, "R5");
        // R11: unmapped addresses
        step(1, 4'h8, 32'hFFFF_FFFF, 12'h0, "R11");
        idle(4'h8, "R11");
        idle(4'hC, "R11");
        idle(4'h0, "R11");
        // R9: page-count strobe alone
        step(1, 4'h0, 32'h0010_0000, 12'h0, "R9");
        idle(4'h0, "R9");
        idle(4'h0, "R9");
        // R3: clear everything
        step(1, 4'h4, 32'h0000_0FFF, 12'h0, "R3");
        idle(4'h4, "R3");
        idle(4'h4, "R5");
        // mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            bit [31:0] wd;
            bit [11:0] ev;
            bit wr;
            bit [3:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wd = {lfsr, lfsr ^ 16'h5A3C};
            ev = (lfsr[3:0] < 4'd5) ? 12'(1 << lfsr[7:4]) : 12'h0;
            wr = lfsr[9] & lfsr[11];
            a  = {lfsr[14] & lfsr[15], 1'b0, lfsr[12], 1'b0};
            step(wr, a, wd, ev, "R2");
        end
        idle(4'h4, "R3");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule